// File: doc/BRIEF.md
# Burst Beat Address and Lane Generator

This block turns one read or write address request (start address, beat size, beat count field and burst kind) into a sequence of beats. Each beat carries the byte address of the beat, the byte lanes of the data bus that the beat really uses, and a flag that marks the final beat. Downstream logic advances the sequence with a ready/valid handshake.

The first beat of an incrementing burst may begin part-way into its size-aligned window, so it can use fewer lanes than the beat size allows. Every later beat starts on the next size-aligned address. Wrapping bursts stay inside a container of beat size times beat count bytes. When a beat is narrower than the bus, its active lanes move across the bus as the address moves.

A request is taken only while no burst is in progress. A request the block cannot legally step through is refused with a one-cycle error pulse and produces no beats.

Top module: `burst_beat_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `beat_valid` is 0 and `req_err` is 0. `req_ready` is 1 exactly when no beat is pending, and a request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R2: One cycle after a legal request is taken, `beat_valid` is 1 and `beat_addr` equals the request's start address.
- R3: For the first beat, `beat_mask` bit i (lane i = address modulo bus byte width) is set exactly for lanes from the start lane up to the last lane of the 2^`req_size`-byte aligned window that holds the start address.
- R4: In an incrementing burst (`req_wrap`=0), each beat after the first has the address of the previous beat rounded down to a multiple of 2^`req_size`, plus 2^`req_size`.
- R5: A beat at an aligned address enables exactly 2^`req_size` consecutive lanes, starting at lane (address modulo bus byte width).
- R6: A burst has `req_len`+1 beats. `beat_last` is 1 only on the final beat. The cycle after the final beat is handed over, `req_ready` is 1 again.
- R7: In a wrapping burst (`req_wrap`=1), the container is 2^`req_size` × (`req_len`+1) bytes, aligned to its own size. Each next address is the previous address plus 2^`req_size`, and it returns to the container's base when it would reach the container's upper boundary.
- R8: A request is illegal if 2^`req_size` exceeds the bus byte width, or if it is a wrap request with an unaligned start or with `req_len` not in {1, 3, 7, 15}. An illegal request makes `req_err` 1 for exactly the one cycle after it is taken, and it produces no beat.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr`, `beat_mask` and `beat_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 3 | log2 of bytes per beat |
| req_len | input | 8 | Beat count minus one |
| req_wrap | input | 1 | 1 = wrapping burst, 0 = incrementing |
| req_err | output | 1 | One-cycle pulse for a refused request |
| beat_valid | output | 1 | Beat outputs are valid |
| beat_ready | input | 1 | Consumer takes the current beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_mask | output | DATA_W/8 | Active byte lanes of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The first beat or the error pulse is due one cycle after the request edge. Every following beat is due one cycle after the edge on which the previous beat was handed over, and `req_ready` returns one cycle after the final handover. The bench drives inputs at negative edges and samples outputs there. It keeps its own beat index, which advances only on an edge where it held `beat_ready` high, so each expected value is compared in the cycle it is due. In stalled cycles the bench checks the same beat again, which exercises the hold rule.

// File: rtl/bbg_pkg.sv
package bbg_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gen_state_e;

  // wrap bursts accept only power-of-two beat counts 2..16
  function automatic logic wrap_count_ok(input logic [7:0] len_field);
    return (len_field == 8'd1) || (len_field == 8'd3) ||
           (len_field == 8'd7) || (len_field == 8'd15);
  endfunction

endpackage

// File: rtl/bbg_req_check.sv
module bbg_req_check #(
  parameter int ADDR_W   = 32,
  parameter int SIZE_MAX = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [7:0]        len_field,
  input  logic              wrap,
  output logic              legal
);
  import bbg_pkg::*;

  function automatic logic [ADDR_W-1:0] offset_mask(input logic [2:0] sz);
    return (ADDR_W'(1) << sz) - ADDR_W'(1);
  endfunction

  logic size_ok;
  logic start_aligned;

  assign size_ok       = (int'(size) <= SIZE_MAX);
  assign start_aligned = ((addr & offset_mask(size)) == '0);
  assign legal = size_ok && (!wrap || (start_aligned && wrap_count_ok(len_field)));

endmodule

// File: rtl/bbg_addr_step.sv
module bbg_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  logic [7:0]        len_field,
  input  logic              wrap,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cont_mask
);

  function automatic logic [ADDR_W-1:0] beat_bytes(input logic [2:0] sz);
    return ADDR_W'(1) << sz;
  endfunction

  function automatic logic [ADDR_W-1:0] container_mask(input logic [2:0] sz,
                                                       input logic [7:0] lf);
    return ((ADDR_W'(lf) + ADDR_W'(1)) << sz) - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] round_down(input logic [ADDR_W-1:0] a,
                                                   input logic [2:0] sz);
    return a & ~(beat_bytes(sz) - ADDR_W'(1));
  endfunction

  logic [ADDR_W-1:0] linear_next;

  assign cont_mask   = container_mask(size, len_field);
  assign linear_next = round_down(cur_addr, size) + beat_bytes(size);
  assign next_addr   = wrap ? ((cur_addr & ~cont_mask) | (linear_next & cont_mask))
                            : linear_next;

endmodule

// File: rtl/bbg_lane_mask.sv
module bbg_lane_mask #(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic [STRB_W-1:0] mask
);
  localparam int LW = $clog2(STRB_W);

  function automatic logic [LW:0] lane_span(input logic [2:0] sz);
    return (LW+1)'(1) << sz;
  endfunction

  logic [LW-1:0] first_lane;
  logic [LW:0]   win_base;
  logic [LW:0]   last_lane;

  assign first_lane = addr[LW-1:0];
  assign win_base   = {1'b0, first_lane & ~(LW'(lane_span(size)) - LW'(1))};
  assign last_lane  = win_base + lane_span(size) - (LW+1)'(1);

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    assign mask[i] = ((LW+1)'(i) >= {1'b0, first_lane}) && ((LW+1)'(i) <= last_lane);
  end

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [7:0]        req_len,
  input  logic              req_wrap,
  output logic              req_err,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [DATA_W/8-1:0] beat_mask,
  output logic              beat_last
);
  import bbg_pkg::*;

  localparam int STRB_W   = DATA_W / 8;
  localparam int SIZE_MAX = $clog2(STRB_W);

  gen_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [7:0]        len_q;
  logic              wrap_q;
  logic [7:0]        left_q;
  logic              err_q;

  // named internal events
  logic              take_req;
  logic              req_legal;
  logic              beat_fire;
  logic [ADDR_W-1:0] step_addr;
  logic [ADDR_W-1:0] wrap_cont;
  logic [ADDR_W-1:0] cur_bytes;

  bbg_req_check #(.ADDR_W(ADDR_W), .SIZE_MAX(SIZE_MAX)) u_check (
    .addr(req_addr), .size(req_size), .len_field(req_len), .wrap(req_wrap),
    .legal(req_legal)
  );

  bbg_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr(addr_q), .size(size_q), .len_field(len_q), .wrap(wrap_q),
    .next_addr(step_addr), .cont_mask(wrap_cont)
  );

  bbg_lane_mask #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_mask (
    .addr(addr_q), .size(size_q), .mask(beat_mask)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign take_req   = req_valid && req_ready;
  assign beat_valid = (state_q == ST_RUN);
  assign beat_addr  = addr_q;
  assign beat_last  = (left_q == 8'd0);
  assign beat_fire  = beat_valid && beat_ready;
  assign req_err    = err_q;
  assign cur_bytes  = ADDR_W'(1) << size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      len_q   <= '0;
      wrap_q  <= 1'b0;
      left_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take_req && !req_legal;
      if (take_req && req_legal) begin
        state_q <= ST_RUN;
        addr_q  <= req_addr;
        size_q  <= req_size;
        len_q   <= req_len;
        wrap_q  <= req_wrap;
        left_q  <= req_len;
      end else if (beat_fire) begin
        if (beat_last) begin
          state_q <= ST_IDLE;
        end else begin
          addr_q <= step_addr;
          left_q <= left_q - 8'd1;
        end
      end
    end
  end

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && req_legal |=> beat_valid && (beat_addr == $past(req_addr)));

  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && !req_legal |=> req_err && !beat_valid);

  // R4
  later_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last |=> ((beat_addr & (cur_bytes - ADDR_W'(1))) == '0));

  // R7
  wrap_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last && wrap_q |=>
      (((beat_addr ^ $past(beat_addr)) & ~wrap_cont) == '0));

  // R5
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ($countones(beat_mask) >= 1) &&
                   (ADDR_W'($countones(beat_mask)) <= cur_bytes));

  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && beat_last |=> req_ready);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
                                 $stable(beat_mask) && $stable(beat_last));

endmodule

// File: tb/burst_beat_gen_tb.sv
module burst_beat_gen_tb;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int STRB_W = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_size = '0;
  logic [7:0]        req_len = '0;
  logic              req_wrap = 1'b0;
  logic              req_err;
  logic              beat_valid;
  logic              beat_ready = 1'b0;
  logic [ADDR_W-1:0] beat_addr;
  logic [STRB_W-1:0] beat_mask;
  logic              beat_last;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  burst_beat_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_len(req_len),
    .req_wrap(req_wrap), .req_err(req_err), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_mask(beat_mask),
    .beat_last(beat_last)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic longint want_addr(longint start, int sz, int lf, bit wrp, int i);
    longint nb = longint'(1) << sz;
    longint cont, base;
    if (!wrp) return (i == 0) ? start : ((start / nb) + i) * nb;
    cont = nb * (lf + 1);
    base = start - (start % cont);
    return base + (((start - base) + i * nb) % cont);
  endfunction

  function automatic longint want_mask(longint a, int sz);
    longint nb = longint'(1) << sz;
    longint first = a % STRB_W;
    longint wlo = (a - (a % nb)) % STRB_W;
    longint m = 0;
    for (int l = 0; l < STRB_W; l++)
      if (l >= first && l <= wlo + nb - 1) m |= (longint'(1) << l);
    return m;
  endfunction

  function automatic bit want_legal(longint a, int sz, int lf, bit wrp);
    longint nb = longint'(1) << sz;
    if (nb > STRB_W) return 1'b0;
    if (wrp && ((a % nb) != 0)) return 1'b0;
    if (wrp && !(lf == 1 || lf == 3 || lf == 7 || lf == 15)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_req(input longint a, input int sz, input int lf, input bit wrp);
    bit ok = want_legal(a, sz, lf, wrp);
    bit stalled = 1'b0;
    int i = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready while idle", longint'(req_ready), 1);
    req_addr = ADDR_W'(a); req_size = 3'(sz); req_len = 8'(lf); req_wrap = wrp;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    if (!ok) begin
      @(negedge clk);
      check(req_err == 1'b1, "R8 error pulse", longint'(req_err), 1);
      check(beat_valid == 1'b0, "R8 no beat", longint'(beat_valid), 0);
      @(negedge clk);
      check(req_err == 1'b0, "R8 pulse one cycle", longint'(req_err), 0);
      return;
    end
    while (i <= lf) begin
      bit rdy;
      longint ea = want_addr(a, sz, lf, wrp, i);
      @(negedge clk);
      check(beat_valid == 1'b1, "R6 beat present", longint'(beat_valid), 1);
      // stalled cycles re-check the same beat: R9
      check(longint'(beat_addr) == ea,
            stalled ? "R9 addr hold" : (i == 0 ? "R2 first addr" : (wrp ? "R7 wrap addr" : "R4 incr addr")),
            longint'(beat_addr), ea);
      check(longint'(beat_mask) == want_mask(ea, sz),
            stalled ? "R9 mask hold" : (i == 0 ? "R3 first mask" : "R5 lane mask"),
            longint'(beat_mask), want_mask(ea, sz));
      check(beat_last == (i == lf), "R6 last flag", longint'(beat_last), longint'(i == lf));
      rdy = ($urandom % 4) != 0;
      beat_ready = rdy;
      @(posedge clk);
      #1 beat_ready = 1'b0;
      stalled = !rdy;
      if (rdy) i++;
    end
    @(negedge clk);
    check(req_ready == 1'b1 && beat_valid == 1'b0, "R6 idle after last",
          longint'({req_ready, beat_valid}), 2);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", longint'(req_ready), 1);
    check(beat_valid == 1'b0, "R1 reset valid", longint'(beat_valid), 0);
    check(req_err == 1'b0, "R1 reset err", longint'(req_err), 0);

    run_req(64'h00, 2, 3, 1'b0);   // aligned baseline
    run_req(64'h01, 2, 4, 1'b0);   // partial first beat
    run_req(64'h07, 2, 4, 1'b0);   // single-lane first beat, lane 7
    run_req(64'h04, 2, 3, 1'b1);   // wrap 04,08,0C,00
    run_req(64'h35, 0, 7, 1'b0);   // byte beats
    run_req(64'h13, 3, 2, 1'b0);   // full-width partial start
    run_req(64'h06, 1, 15, 1'b1);  // wrap 16 beats of 2 bytes
    run_req(64'h02, 2, 3, 1'b1);   // R8 unaligned wrap
    run_req(64'h08, 2, 2, 1'b1);   // R8 wrap count 3
    run_req(64'h00, 4, 0, 1'b0);   // R8 size wider than bus

    for (int n = 0; n < 60; n++) begin
      int sz = $urandom % 5;
      bit wrp = $urandom % 2;
      int lf = (wrp && ($urandom % 4 != 0)) ? ((2 << ($urandom % 4)) - 1) : ($urandom % 16);
      longint a = longint'($urandom % 4096);
      if (wrp && ($urandom % 4 != 0)) a = a - (a % (longint'(1) << sz));
      run_req(a, sz, lf, wrp);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule